// File: doc/BRIEF.md
# Shared Bus Request/Grant Arbiter with Bypass Strap

This block decides which of eight downstream masters, or the bridge itself, may drive a shared parallel bus. Masters ask for the bus on active-low request lines and are answered on active-low grant lines. When nobody asks, ownership rests with the bridge, which may then drive the address/data, command and parity lines to valid levels. An output enable tells the datapath when that parking drive is wanted.

A strap input, captured only while reset is high, chooses between two modes. With the strap low the internal arbiter runs, rotating priority over nine positions. With the strap high the internal arbiter is switched off. Request pin 0 then becomes the bridge's grant input from an outside arbiter, and grant pin 0 becomes the bridge's request output. Grant pins 7 to 1 stay idle in that mode.

Whenever ownership moves, every grant is withdrawn for at least two clocks before the next owner receives one. All outputs come straight from registers, and the reset is synchronous and active high.

Top module: `sec_bus_arbiter`

## Requirements
- R1: One clock edge with `rst` high leaves all grant outputs high (deasserted), `bridge_owns_o` low and `park_drive_o` low.
- R2: In internal mode, at most one owner exists at any time. The owner is either one low bit of `gnt_n_o` or `bridge_owns_o` high, never both.
- R3: In internal mode, nine positions are arbitrated: master i is position i (0 to 7) and the bridge (`bridge_req_i`) is position 8. The search for a new owner begins at the position after the last winner and wraps around. After reset it begins at master 0.
- R4: An owner keeps the bus while its own request stays active and no other position requests. The owner loses the bus in the edge that sees another position requesting, or that sees its own request withdrawn. The bridge, when it holds the bus without requesting, loses it only to another request.
- R5: Between any two owners there are at least two clocks in which no grant is asserted and `bridge_owns_o` is low. An owner is never replaced directly by another.
- R6: In internal mode, when the search finds no request, the bridge becomes owner. `park_drive_o` is high one edge after an edge at which the bridge becomes or stays owner with `bus_idle_i` high, and low otherwise.
- R7: The strap `cfn_strap_i` is captured only while `rst` is high. A change of the strap outside reset has no effect on the mode. Low selects internal mode and high selects external mode.
- R8: In external mode, `gnt_n_o[7:1]` stay high. `gnt_n_o[0]` is the registered inverse of `bridge_req_i`, so it is low one edge after the bridge requests. `bridge_owns_o` is the registered inverse of `req_n_i[0]`, and `park_drive_o` follows rule R6 using that ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high; strap is captured while high |
| cfn_strap_i | input | 1 | Mode strap: 0 selects internal arbitration, 1 selects external arbitration |
| req_n_i | input | 8 | Active-low master requests; bit 0 is the grant input in external mode |
| bridge_req_i | input | 1 | Bridge wants the bus, active high |
| bus_idle_i | input | 1 | Bus has no transaction in progress, active high |
| gnt_n_o | output | 8 | Active-low master grants; bit 0 is the request output in external mode |
| bridge_owns_o | output | 1 | The bridge holds the bus |
| park_drive_o | output | 1 | Drive the address/data, command and parity lines to park the bus |

## Verification
A table of request patterns walks the arbiter through several cases. A lone master distinguishes plain granting from parking. Two competing masters show that priority rotates instead of staying fixed. A release through withdrawal is contrasted with a release through a competing request, and a high master against master 0 proves that the search wraps past the bridge position. Every row also checks the two idle clocks after each release. Directed runs toggle the strap outside reset to show that it is ignored. They also run external mode with all masters requesting, to show that only pin 0 carries meaning there.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Arbitration mode latched from the strap during reset
  typedef enum logic {
    MODE_INTERNAL = 1'b0,
    MODE_EXTERNAL = 1'b1
  } arb_mode_e;

  // Default number of idle clocks between two owners
  localparam int unsigned ARB_DEFAULT_GAP = 2;

endpackage

// File: rtl/arb_rr_pick.sv
// Rotating-priority search: first set request at or after position last+1.
module arb_rr_pick #(
  parameter int unsigned N  = 9,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] win
);

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < int'(N); k++) begin
      int idx;
      idx = (int'(last) + 1 + k) % int'(N);
      if (!found && req[idx]) begin
        found = 1'b1;
        win   = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/arb_gap_timer.sv
// Holds off any new owner for GAP clocks after a release.
module arb_gap_timer #(
  parameter int unsigned GAP = 2,
  localparam int unsigned CW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(GAP - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/arb_ext_port.sv
// Pin remapping for external arbitration: pin 0 pair swaps roles.
module arb_ext_port #(
  parameter int unsigned NM = 8
) (
  input  logic          bridge_req,
  input  logic          gnt_in_n,
  output logic [NM-1:0] pins_n,
  output logic          owns
);

  for (genvar i = 0; i < int'(NM); i++) begin : g_pin
    if (i == 0) begin : g_req_out
      assign pins_n[i] = ~bridge_req;
    end else begin : g_idle
      assign pins_n[i] = 1'b1;
    end
  end

  assign owns = ~gnt_in_n;

endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 8,
  parameter int unsigned MIN_GAP     = ARB_DEFAULT_GAP
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfn_strap_i,
  input  logic [NUM_MASTERS-1:0] req_n_i,
  input  logic                   bridge_req_i,
  input  logic                   bus_idle_i,
  output logic [NUM_MASTERS-1:0] gnt_n_o,
  output logic                   bridge_owns_o,
  output logic                   park_drive_o
);

  localparam int unsigned N      = NUM_MASTERS + 1;
  localparam int unsigned IW     = $clog2(N);
  localparam int unsigned BRIDGE = NUM_MASTERS;

  arb_mode_e mode_q;
  logic      ext_q;

  // Strap is only looked at while reset is high
  always_ff @(posedge clk) begin
    if (rst) mode_q <= arb_mode_e'(cfn_strap_i);
  end
  assign ext_q = (mode_q == MODE_EXTERNAL);

  // Internal arbiter state
  logic [N-1:0]  req_vec;
  logic [N-1:0]  hold_q, hold_d;
  logic [IW-1:0] last_q, last_d;
  logic          found;
  logic [IW-1:0] win;
  logic          gap_busy;
  logic          holding, holder_req, others, release_now, pick_now;

  assign req_vec = {bridge_req_i, ~req_n_i};

  arb_rr_pick #(.N(N)) i_pick (
    .req  (req_vec),
    .last (last_q),
    .found(found),
    .win  (win)
  );

  arb_gap_timer #(.GAP(MIN_GAP)) i_gap (
    .clk  (clk),
    .rst  (rst),
    .start(release_now),
    .busy (gap_busy)
  );

  assign holding     = |hold_q;
  assign holder_req  = |(hold_q & req_vec);
  assign others      = |(req_vec & ~hold_q);
  assign release_now = !ext_q && holding && !gap_busy &&
                       (others || (!holder_req && !hold_q[BRIDGE]));
  assign pick_now    = !ext_q && !holding && !gap_busy;

  always_comb begin
    hold_d = hold_q;
    last_d = last_q;
    if (ext_q || release_now) begin
      hold_d = '0;
    end else if (pick_now) begin
      if (found) begin
        hold_d = N'(1) << win;
        last_d = win;
      end else begin
        hold_d = N'(1) << BRIDGE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      last_q <= IW'(BRIDGE);
    end else begin
      hold_q <= hold_d;
      last_q <= last_d;
    end
  end

  // External mode pin mapping
  logic [NUM_MASTERS-1:0] ext_pins_n;
  logic                   ext_owns;

  arb_ext_port #(.NM(NUM_MASTERS)) i_ext (
    .bridge_req(bridge_req_i),
    .gnt_in_n  (req_n_i[0]),
    .pins_n    (ext_pins_n),
    .owns      (ext_owns)
  );

  // Registered outputs
  logic owns_d;
  assign owns_d = ext_q ? ext_owns : hold_d[BRIDGE];

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_n_o       <= '1;
      bridge_owns_o <= 1'b0;
      park_drive_o  <= 1'b0;
    end else begin
      gnt_n_o       <= ext_q ? ext_pins_n : ~hold_d[NUM_MASTERS-1:0];
      bridge_owns_o <= owns_d;
      park_drive_o  <= owns_d && bus_idle_i;
    end
  end

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned NM = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ext_q,
  input logic [NM-1:0] req_n_i,
  input logic          bridge_req_i,
  input logic [NM-1:0] gnt_n_o,
  input logic          bridge_owns_o,
  input logic          park_drive_o
);

  logic any_own;
  assign any_own = bridge_owns_o || !(&gnt_n_o);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (gnt_n_o == '1 && !bridge_owns_o && !park_drive_o));

  assert_single_owner_R2: assert property (@(posedge clk) disable iff (rst)
    !ext_q |-> $onehot0({bridge_owns_o, ~gnt_n_o}));

  assert_gap_two_R5: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && $fell(any_own)) |=> !any_own);

  assert_no_swap_R5: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && any_own && $past(any_own)) |-> $stable({bridge_owns_o, gnt_n_o}));

  assert_park_owner_R6: assert property (@(posedge clk) disable iff (rst)
    park_drive_o |-> bridge_owns_o);

  assert_strap_held_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(ext_q));

  assert_ext_pins_R8: assert property (@(posedge clk) disable iff (rst)
    ext_q |-> (&gnt_n_o[NM-1:1]));

  assert_ext_pair_R8: assert property (@(posedge clk) disable iff (rst)
    ext_q |=> (gnt_n_o[0] == !$past(bridge_req_i) &&
               bridge_owns_o == !$past(req_n_i[0])));

endmodule

bind sec_bus_arbiter arb_checker #(.NM(NUM_MASTERS)) i_arb_checker (
  .clk          (clk),
  .rst          (rst),
  .ext_q        (ext_q),
  .req_n_i      (req_n_i),
  .bridge_req_i (bridge_req_i),
  .gnt_n_o      (gnt_n_o),
  .bridge_owns_o(bridge_owns_o),
  .park_drive_o (park_drive_o)
);

// File: tb/test_sec_bus_arbiter.sv
module test_sec_bus_arbiter;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfn_strap_i;
  logic [7:0] req_n_i;
  logic       bridge_req_i;
  logic       bus_idle_i;
  logic [7:0] gnt_n_o;
  logic       bridge_owns_o;
  logic       park_drive_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sec_bus_arbiter i_sec_bus_arbiter (
    .clk          (clk),
    .rst          (rst),
    .cfn_strap_i  (cfn_strap_i),
    .req_n_i      (req_n_i),
    .bridge_req_i (bridge_req_i),
    .bus_idle_i   (bus_idle_i),
    .gnt_n_o      (gnt_n_o),
    .bridge_owns_o(bridge_owns_o),
    .park_drive_o (park_drive_o)
  );

  // Row: req_n[19:12] breq[11] idle[10] | exp gnt_n[9:2] owns[1] park[0]
  // Internal mode, one clock per row. Covers R3, R4, R5, R6.
  localparam int ROWS = 27;
  localparam logic [19:0] TABLE [ROWS] = '{
    {8'hFF,1'b0,1'b1, 8'hFF,1'b1,1'b1},  // 0 nothing pending: park (R6)
    {8'hFB,1'b0,1'b1, 8'hFF,1'b0,1'b0},  // 1 m2 asks: bridge releases (R4)
    {8'hFB,1'b0,1'b1, 8'hFF,1'b0,1'b0},  // 2 gap (R5)
    {8'hFB,1'b0,1'b1, 8'hFB,1'b0,1'b0},  // 3 m2 granted
    {8'hFB,1'b0,1'b1, 8'hFB,1'b0,1'b0},  // 4 held (R4)
    {8'hDB,1'b0,1'b1, 8'hFF,1'b0,1'b0},  // 5 m5 competes: release
    {8'hDB,1'b0,1'b1, 8'hFF,1'b0,1'b0},  // 6 gap
    {8'hDB,1'b0,1'b1, 8'hDF,1'b0,1'b0},  // 7 rotation gives m5 (R3)
    {8'hDB,1'b0,1'b1, 8'hFF,1'b0,1'b0},  // 8 m2 still pending: release
    {8'hDB,1'b0,1'b1, 8'hFF,1'b0,1'b0},  // 9 gap
    {8'hDB,1'b0,1'b1, 8'hFB,1'b0,1'b0},  // 10 rotation back to m2
    {8'hFF,1'b1,1'b1, 8'hFF,1'b0,1'b0},  // 11 m2 withdraws, bridge asks
    {8'hFF,1'b1,1'b1, 8'hFF,1'b0,1'b0},  // 12 gap
    {8'hFF,1'b1,1'b1, 8'hFF,1'b1,1'b1},  // 13 bridge wins
    {8'hFE,1'b1,1'b0, 8'hFF,1'b0,1'b0},  // 14 m0 competes: release
    {8'hFE,1'b1,1'b0, 8'hFF,1'b0,1'b0},  // 15 gap
    {8'hFE,1'b1,1'b0, 8'hFE,1'b0,1'b0},  // 16 after bridge comes m0
    {8'hFF,1'b0,1'b1, 8'hFF,1'b0,1'b0},  // 17 m0 withdraws (R4)
    {8'hFF,1'b0,1'b1, 8'hFF,1'b0,1'b0},  // 18 gap
    {8'hFF,1'b0,1'b1, 8'hFF,1'b1,1'b1},  // 19 park
    {8'hFF,1'b0,1'b0, 8'hFF,1'b1,1'b0},  // 20 bus busy: no park drive (R6)
    {8'h7F,1'b0,1'b0, 8'hFF,1'b0,1'b0},  // 21 m7 asks
    {8'h7F,1'b0,1'b0, 8'hFF,1'b0,1'b0},  // 22 gap
    {8'h7F,1'b0,1'b0, 8'h7F,1'b0,1'b0},  // 23 m7 granted
    {8'h7E,1'b0,1'b0, 8'hFF,1'b0,1'b0},  // 24 m0 competes
    {8'h7E,1'b0,1'b0, 8'hFF,1'b0,1'b0},  // 25 gap
    {8'h7E,1'b0,1'b0, 8'hFE,1'b0,1'b0}   // 26 search wraps to m0 (R3)
  };

  task automatic check_out(input string tag, input logic [7:0] eg,
                           input logic eo, input logic ep);
    checks++;
    if (gnt_n_o !== eg || bridge_owns_o !== eo || park_drive_o !== ep) begin
      errors++;
      $display("FAIL %s: gnt_n=%h owns=%b park=%b expected gnt_n=%h owns=%b park=%b",
               tag, gnt_n_o, bridge_owns_o, park_drive_o, eg, eo, ep);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfn_strap_i = 1'b0; req_n_i = 8'hFF;
    bridge_req_i = 1'b0; bus_idle_i = 1'b1;
    repeat (3) step();
    check_out("R1 reset state", 8'hFF, 1'b0, 1'b0);
    rst = 1'b0;

    for (int r = 0; r < ROWS; r++) begin
      req_n_i      = TABLE[r][19:12];
      bridge_req_i = TABLE[r][11];
      bus_idle_i   = TABLE[r][10];
      step();
      check_out($sformatf("R3/R4/R5/R6 row %0d", r),
                TABLE[r][9:2], TABLE[r][1], TABLE[r][0]);
    end

    // R1: reset while a master holds the bus
    rst = 1'b1;
    step(); step();
    check_out("R1 reset during grant", 8'hFF, 1'b0, 1'b0);

    // R7: strap raised outside reset is ignored, arbiter stays internal
    rst = 1'b0; cfn_strap_i = 1'b1;
    req_n_i = 8'hFF; bridge_req_i = 1'b0; bus_idle_i = 1'b1;
    step();
    check_out("R7 strap ignored, park", 8'hFF, 1'b1, 1'b1);
    step();
    check_out("R7 strap ignored, still internal", 8'hFF, 1'b1, 1'b1);

    // R8: external mode selected by reset with strap high
    rst = 1'b1;
    step(); step();
    rst = 1'b0; bridge_req_i = 1'b1; req_n_i = 8'hFF;
    step();
    check_out("R8 request out on pin 0", 8'hFE, 1'b0, 1'b0);
    req_n_i = 8'h00;
    step();
    check_out("R8 grant in, pins 7..1 idle", 8'hFE, 1'b1, 1'b1);
    cfn_strap_i = 1'b0; bridge_req_i = 1'b0; bus_idle_i = 1'b0;
    step();
    check_out("R7 strap drop ignored in external mode", 8'hFF, 1'b1, 1'b0);
    req_n_i = 8'hFF;
    step();
    check_out("R8 grant in withdrawn", 8'hFF, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule